// File: doc/BRIEF.md
# Vectored Interrupt Enable Controller

This block decides when a small microcontroller core should take an interrupt and which one. Seven event sources feed it: a divider overflow, two timer underflows, a change on an input port, a falling edge on an external active-low pin, serial receive done and serial transmit done. Each source pulse sets a sticky event flag. An 8-bit enable register, loaded by a single write strobe, chooses which flags may raise an interrupt. A global interrupt-on state gates the whole request.

When at least one enabled flag is pending and interrupts are globally on, the block raises a request and presents a 3-bit vector. The vector is the lowest pending line index. When the core accepts, the block clears that one flag and turns interrupts globally off. They stay off until software writes the enable register again or issues the global-enable strobe. A separate global-disable strobe turns interrupts off and leaves the stored enable bits as they are.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After synchronous reset the request is low, all event flags are clear, the enable register holds zero and interrupts are globally off.
- R2: A one-cycle pulse on a source sets its event flag whether or not that line is enabled. The flag stays set until that line is accepted. Line indices: 0 divider overflow, 1 timer-0 underflow, 2 port change, 4 external pin, 5 receive done, 6 transmit done, 7 timer-1 underflow.
- R3: The external pin passes through a two-flop synchronizer and then a falling-edge detector. A high-to-low change sets flag 4 on the third rising clock edge after the change. A low-to-high change sets nothing.
- R4: The request output is high exactly when interrupts are globally on and some flag is set whose enable bit is also set. Line 3 is reserved and never requests, whatever its enable bit holds.
- R5: The vector output is the binary index of the lowest-numbered line that is both pending and enabled.
- R6: An accept (irq_ack high while the request is high) clears only the flag at the presented vector and turns interrupts globally off. The request is low in the following cycle, and all other flags keep their values.
- R7: A write of the enable register loads all 8 bits and turns interrupts globally on. The global-enable strobe turns them on without changing the enable bits. Neither action changes any flag.
- R8: The global-disable strobe turns interrupts off and keeps the stored enable bits. A later global-enable strobe restores the same request and vector.
- R9: irq_ack while the request is low has no effect on the flags or on the global state.
- R10: If a source pulses in the same cycle its line is accepted, the flag stays set.
- R11: In any cycle where an accept or a global disable coincides with an enable-register write or a global-enable strobe, interrupts end the cycle globally off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ovf | input | 1 | Divider overflow pulse (line 0) |
| tmr0_unf | input | 1 | Timer-0 underflow pulse (line 1) |
| port_chg | input | 1 | Port change pulse (line 2) |
| ext_pin_n | input | 1 | Asynchronous external pin, idle high, falling edge requests (line 4) |
| rx_done | input | 1 | Serial receive done pulse (line 5) |
| tx_done | input | 1 | Serial transmit done pulse (line 6) |
| tmr1_unf | input | 1 | Timer-1 underflow pulse (line 7) |
| en_wr | input | 1 | Load enable register from en_data and turn interrupts on |
| en_data | input | 8 | Enable bits, bit n gates line n |
| gie_set | input | 1 | Global enable strobe |
| gie_clr | input | 1 | Global disable strobe |
| irq_ack | input | 1 | Core accepts the current request |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 3 | Index of the line being requested |

## Verification
The main function is swept over every enable value against every combination of the six pulse-driven sources. This shows that the request depends on the overlap of flags and enables, and not on either one alone. It also shows that the vector follows the lowest overlapping index, and that reserved line 3 never wins. A drain sequence accepts pending lines one by one. It tells apart clearing only the vectored flag from clearing all of them, and it shows that re-enabling restores the next vector. Directed cases set accept, disable and enable strobes against each other and against a same-cycle source pulse. Another case drives the external pin low and then high, which shows the synchronizer latency and that only the falling edge counts.

// File: rtl/irq_pkg.sv
package irq_pkg;

    parameter int unsigned IRQ_LINES = 8;
    localparam int unsigned VEC_W = $clog2(IRQ_LINES);

    typedef logic [IRQ_LINES-1:0] line_mask_t;
    typedef logic [VEC_W-1:0]     line_idx_t;

    typedef enum logic [VEC_W-1:0] {
        LN_DIV0  = 3'd0,
        LN_TMR0  = 3'd1,
        LN_PORT  = 3'd2,
        LN_RSVD  = 3'd3,
        LN_EXT   = 3'd4,
        LN_RXD   = 3'd5,
        LN_TXD   = 3'd6,
        LN_TMR1  = 3'd7
    } line_id_e;

    localparam line_mask_t RSVD_MASK = line_mask_t'(1) << LN_RSVD;

    typedef struct packed {
        logic      hit;
        line_idx_t idx;
    } pick_t;

    function automatic pick_t pick_lowest(input line_mask_t m);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = IRQ_LINES - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.hit = 1'b1;
                r.idx = line_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic line_mask_t idx_to_onehot(input line_idx_t idx);
        return line_mask_t'(1) << idx;
    endfunction

endpackage

// File: rtl/irq_pin_fall.sv
module irq_pin_fall #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= pin_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= sync_q[STAGES-1];
    end

    assign fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_mask_t set_i,
    input  line_mask_t clr_i,
    output line_mask_t flag_o
);
    line_mask_t flag_q;

    genvar g;
    generate
        for (g = 0; g < IRQ_LINES; g++) begin : g_flag
            if (RSVD_MASK[g]) begin : g_rsvd
                always_ff @(posedge clk) flag_q[g] <= 1'b0;
            end else begin : g_live
                always_ff @(posedge clk) begin
                    if (rst)           flag_q[g] <= 1'b0;
                    else if (set_i[g]) flag_q[g] <= 1'b1;
                    else if (clr_i[g]) flag_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    assign flag_o = flag_q;

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  line_mask_t en_data,
    input  logic       gie_set,
    input  logic       gie_clr,
    input  logic       take,
    output line_mask_t en_o,
    output logic       gie_o
);
    line_mask_t en_q;
    logic       gie_q;
    logic       turn_off;
    logic       turn_on;

    assign turn_off = take | gie_clr;
    assign turn_on  = en_wr | gie_set;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_data;
    end

    always_ff @(posedge clk) begin
        if (rst)           gie_q <= 1'b0;
        else if (turn_off) gie_q <= 1'b0;
        else if (turn_on)  gie_q <= 1'b1;
    end

    assign en_o  = en_q;
    assign gie_o = gie_q;

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned PIN_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_ovf,
    input  logic             tmr0_unf,
    input  logic             port_chg,
    input  logic             ext_pin_n,
    input  logic             rx_done,
    input  logic             tx_done,
    input  logic             tmr1_unf,
    input  logic             en_wr,
    input  logic [IRQ_LINES-1:0] en_data,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    logic       ext_fall;
    line_mask_t src_set;
    line_mask_t src_clr;
    line_mask_t evt_q;
    line_mask_t en_q;
    logic       gie_q;
    line_mask_t live;
    pick_t      pick;
    logic       take;

    irq_pin_fall #(.STAGES(PIN_SYNC)) u_pin (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_pin_n),
        .fall  (ext_fall)
    );

    always_comb begin
        src_set          = '0;
        src_set[LN_DIV0] = div_ovf;
        src_set[LN_TMR0] = tmr0_unf;
        src_set[LN_PORT] = port_chg;
        src_set[LN_EXT]  = ext_fall;
        src_set[LN_RXD]  = rx_done;
        src_set[LN_TXD]  = tx_done;
        src_set[LN_TMR1] = tmr1_unf;
    end

    assign take    = irq_ack & irq_req;
    assign src_clr = take ? idx_to_onehot(pick.idx) : '0;

    irq_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (src_set),
        .clr_i  (src_clr),
        .flag_o (evt_q)
    );

    irq_gate_ctrl u_gate (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (en_wr),
        .en_data (en_data),
        .gie_set (gie_set),
        .gie_clr (gie_clr),
        .take    (take),
        .en_o    (en_q),
        .gie_o   (gie_q)
    );

    assign live    = evt_q & en_q & ~RSVD_MASK;
    assign pick    = pick_lowest(live);
    assign irq_req = gie_q & pick.hit;
    assign irq_vec = pick.idx;

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             gie_set,
    input logic             gie_clr,
    input logic             en_wr,
    input logic             gie_q,
    input line_mask_t       evt_q
);
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq_req);

    a_r6_req_drops: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !irq_req);

    a_r6_others_kept: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=>
        ((($past(evt_q) & ~idx_to_onehot($past(irq_vec))) & ~evt_q) == '0));

    a_r4_rsvd_never: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec != LN_RSVD));

    a_r4_off_stays_quiet: assert property (@(posedge clk) disable iff (rst)
        (!gie_q && !en_wr && !gie_set) |=> !irq_req);

    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        gie_clr |=> !irq_req);

    a_r11_off_wins: assert property (@(posedge clk) disable iff (rst)
        ((irq_ack && irq_req) || gie_clr) |=> !gie_q);

endmodule

bind irq_accept_ctrl irq_accept_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_ack (irq_ack),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .gie_set (gie_set),
    .gie_clr (gie_clr),
    .en_wr   (en_wr),
    .gie_q   (gie_q),
    .evt_q   (evt_q)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_ovf = 0, tmr0_unf = 0, port_chg = 0, ext_pin_n = 1;
    logic       rx_done = 0, tx_done = 0, tmr1_unf = 0;
    logic       en_wr = 0, gie_set = 0, gie_clr = 0, irq_ack = 0;
    logic [7:0] en_data = 8'h00;
    logic       irq_req;
    logic [2:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_accept_ctrl dut (
        .clk(clk), .rst(rst),
        .div_ovf(div_ovf), .tmr0_unf(tmr0_unf), .port_chg(port_chg),
        .ext_pin_n(ext_pin_n), .rx_done(rx_done), .tx_done(tx_done),
        .tmr1_unf(tmr1_unf), .en_wr(en_wr), .en_data(en_data),
        .gie_set(gie_set), .gie_clr(gie_clr), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        div_ovf = 0; tmr0_unf = 0; port_chg = 0;
        rx_done = 0; tx_done = 0; tmr1_unf = 0;
        en_wr = 0; gie_set = 0; gie_clr = 0; irq_ack = 0;
    endtask

    task automatic pulse_lines(input logic [7:0] m);
        div_ovf  = m[0]; tmr0_unf = m[1]; port_chg = m[2];
        rx_done  = m[5]; tx_done  = m[6]; tmr1_unf = m[7];
    endtask

    task automatic do_reset();
        @(negedge clk); idle_inputs(); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    task automatic step();
        @(negedge clk); idle_inputs();
    endtask

    function automatic logic [7:0] pat_to_mask(input logic [5:0] p);
        logic [7:0] m;
        m = 8'h00;
        m[0] = p[0]; m[1] = p[1]; m[2] = p[2];
        m[5] = p[3]; m[6] = p[4]; m[7] = p[5];
        return m;
    endfunction

    function automatic int low_idx(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return 0;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m, live;
        do_reset();
        // R1: reset state; gie_set with enables at zero proves enables and flags are clear
        chk("R1 req after reset", irq_req, 0);
        gie_set = 1; step();
        chk("R1 enables and flags zero", irq_req, 0);

        // R2 R4 R5: sweep every enable value against every source pattern
        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < 64; p++) begin
                m = pat_to_mask(6'(p));
                do_reset();
                pulse_lines(m); en_wr = 1; en_data = 8'(e);
                step();
                live = m & 8'(e) & 8'hF7;
                chk("R4 request sweep", irq_req, int'(live != 0));
                if (live != 0) chk("R5 vector sweep", irq_vec, low_idx(live));
            end
        end

        // R2: flag latched while disabled, seen after enabling
        do_reset();
        tx_done = 1; step();
        chk("R2 disabled no req", irq_req, 0);
        en_wr = 1; en_data = 8'hFF; step();
        chk("R2 latched req", irq_req, 1);
        chk("R2 latched vec", irq_vec, 6);

        // R6 R7: drain lines 1,5,7 one by one
        do_reset();
        pulse_lines(8'hA2); en_wr = 1; en_data = 8'hFF; step();
        chk("R6 first vec", irq_vec, 1);
        irq_ack = 1; step();
        chk("R6 req low after accept", irq_req, 0);
        gie_set = 1; step();
        chk("R7 gie_set restores req", irq_req, 1);
        chk("R6 others kept vec", irq_vec, 5);
        irq_ack = 1; step();
        chk("R6 req low after second accept", irq_req, 0);
        en_wr = 1; en_data = 8'hFF; step();
        chk("R7 enable write restores vec", irq_vec, 7);
        irq_ack = 1; step();
        gie_set = 1; step();
        chk("R6 all drained", irq_req, 0);

        // R8: global disable keeps enable bits
        do_reset();
        pulse_lines(8'h24); en_wr = 1; en_data = 8'h20; step();
        chk("R8 pre vec", irq_vec, 5);
        gie_clr = 1; step();
        chk("R8 disabled", irq_req, 0);
        gie_set = 1; step();
        chk("R8 restored req", irq_req, 1);
        chk("R8 restored vec", irq_vec, 5);

        // R9: ack while request low changes nothing
        gie_clr = 1; step();
        irq_ack = 1; step();
        chk("R9 still off", irq_req, 0);
        gie_set = 1; step();
        chk("R9 flag kept", irq_vec, 5);

        // R10: pulse on accepted line in the same cycle
        irq_ack = 1; rx_done = 1; step();
        chk("R10 off after accept", irq_req, 0);
        gie_set = 1; step();
        chk("R10 flag kept", irq_req, 1);
        chk("R10 vec", irq_vec, 5);

        // R11: off wins over on
        gie_clr = 1; gie_set = 1; step();
        chk("R11 disable beats set", irq_req, 0);
        gie_set = 1; step();
        irq_ack = 1; en_wr = 1; en_data = 8'h20; rx_done = 1; step();
        chk("R11 accept beats write", irq_req, 0);

        // R4: reserved enable bit alone never requests
        do_reset();
        pulse_lines(8'hE7); en_wr = 1; en_data = 8'h08; step();
        chk("R4 reserved only", irq_req, 0);

        // R3: external pin falling edge latency, rising ignored
        do_reset();
        en_wr = 1; en_data = 8'h10; step();
        ext_pin_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R3 not yet after two edges", irq_req, 0);
        @(negedge clk);
        chk("R3 set on third edge", irq_req, 1);
        chk("R3 vec", irq_vec, 4);
        irq_ack = 1; step();
        ext_pin_n = 1;
        for (int k = 0; k < 5; k++) @(negedge clk);
        gie_set = 1; step();
        chk("R3 rising ignored", irq_req, 0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule